// File: doc/BRIEF.md
# PCI Address Parity Error Reporter

This block sits beside a PCI target and checks the parity of every address that another agent places on the bus. It finds the address phase of each transaction and keeps the address and command lanes from that clock. It then checks them against the parity bit that arrives one clock later. If the check fails, it drives the active-low system-error line low for a single clock.

The system-error line is open-drain. The block therefore presents a driven level and a separate output enable, and an external pull-up returns the line high once the enable drops. Reporting needs two command-register enables, the system-error enable and the parity-response enable. Each report also sets a sticky status flag, which software clears by writing a one.

Top module: `pci_aper_reporter`

## Requirements
- R1: An address phase is a rising clock edge at which `frame_n` is sampled low after it was sampled high at the previous edge. Only the `ad` and `cbe_n` values sampled at that edge are checked, and `frame_n` held low at later edges starts no new check.
- R2: `par` is sampled at the edge after the address phase. The number of ones in the sampled `ad`, `cbe_n` and `par` together must be even. An odd count is an address parity error.
- R3: For an address phase sampled at edge N that has a parity error and meets R4 to R6, `serr_oe` is high from edge N+2 to edge N+3, and only then. While `serr_oe` is high, `serr_n_o` is 0. At all other times `serr_n_o` is 1.
- R4: No error is reported when `ad_out_en` was high at the address-phase edge, which means this device drove the address itself.
- R5: No error is reported unless `serr_en` (command bit 8) is high at edge N+2.
- R6: No error is reported unless `perr_resp_en` (command bit 6) is high at edge N+2.
- R7: Parity errors in data phases, meaning wrong `par` values while `frame_n` stays low after the address phase, never cause a report.
- R8: While `rst_n` is low, `serr_oe` and `sts_serr` are 0, whatever the bus does.
- R9: `sts_serr` rises at the same edge at which `serr_oe` rises, and it stays high until it is cleared.
- R10: `sts_clr` high at an edge clears `sts_serr`. If a new report starts at that same edge, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low transaction framing |
| ad | input | AD_W (32) | Multiplexed address/data bus |
| cbe_n | input | AD_W/8 (4) | Active-low command/byte-enable lanes |
| par | input | 1 | Even parity bit over `ad` and `cbe_n` |
| ad_out_en | input | 1 | High when this device is driving `ad` |
| serr_en | input | 1 | Command register system-error enable (bit 8) |
| perr_resp_en | input | 1 | Command register parity-response enable (bit 6) |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| serr_n_o | output | 1 | Driven level of the system-error line |
| serr_oe | output | 1 | Output enable of the system-error line |
| sts_serr | output | 1 | Sticky signalled-system-error status |

## Verification
The assertions assume that `frame_n` and `ad_out_en` come from a well-behaved bus. They also assume that the enables are settled at the edge where a report is produced and that `sts_clr` is a one-clock strobe. The stimulus issues each transaction from a single task. That task keeps the enables constant until the report edge has passed, leaves at least one idle clock with `frame_n` high between transactions, and drives `ad_out_en` only in the address cycle. Data phases use random values, so wrong data parity is common but always lies outside the address phase.

// File: rtl/pci_aper_pkg.sv
package pci_aper_pkg;
   localparam int unsigned DFLT_AD_W   = 32;
   localparam int unsigned DFLT_LANE_W = 8;

   function automatic int unsigned lane_count(input int unsigned ad_w, input int unsigned lane_w);
      return ad_w / lane_w;
   endfunction
endpackage

// File: rtl/pci_aper_phase.sv
module pci_aper_phase
   import pci_aper_pkg::*;
#(
   parameter int unsigned AD_W   = DFLT_AD_W,
   parameter int unsigned LANE_W = DFLT_LANE_W,
   localparam int unsigned LANES = lane_count(AD_W, LANE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [AD_W-1:0]  ad,
   input  logic [LANES-1:0] cbe_n,
   input  logic             ad_out_en,
   output logic             cap_vld,
   output logic [AD_W-1:0]  cap_ad,
   output logic [LANES-1:0] cap_cbe
);
   logic frame_seen_idle_q;
   logic addr_edge;

   // first low sample of frame after a high sample
   assign addr_edge = !frame_n && frame_seen_idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_seen_idle_q <= 1'b0;
         cap_vld           <= 1'b0;
         cap_ad            <= '0;
         cap_cbe           <= '0;
      end else begin
         frame_seen_idle_q <= frame_n;
         cap_vld           <= addr_edge && !ad_out_en;
         if (addr_edge) begin
            cap_ad  <= ad;
            cap_cbe <= cbe_n;
         end
      end
   end
endmodule

// File: rtl/pci_aper_parity.sv
module pci_aper_parity
   import pci_aper_pkg::*;
#(
   parameter int unsigned AD_W   = DFLT_AD_W,
   parameter int unsigned LANE_W = DFLT_LANE_W,
   localparam int unsigned LANES = lane_count(AD_W, LANE_W)
) (
   input  logic [AD_W-1:0]  ad_s,
   input  logic [LANES-1:0] cbe_s,
   input  logic             par_s,
   output logic             odd
);
   logic [LANES-1:0] lane_par;

   generate
      if (AD_W % LANE_W != 0) begin : g_bad_width
         $error("AD_W must be a multiple of LANE_W");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("at least one byte lane is required");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_par[g] = ^{ad_s[g*LANE_W +: LANE_W], cbe_s[g]};
      end
   endgenerate

   assign odd = ^{lane_par, par_s};
endmodule

// File: rtl/pci_aper_report.sv
module pci_aper_report (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_vld,
   input  logic chk_odd,
   input  logic serr_en,
   input  logic perr_resp_en,
   input  logic sts_clr,
   output logic oe,
   output logic sts
);
   logic err_q;
   logic fire;

   assign fire = err_q && serr_en && perr_resp_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         oe    <= 1'b0;
         sts   <= 1'b0;
      end else begin
         err_q <= chk_vld && chk_odd;
         oe    <= fire;
         if (fire)         sts <= 1'b1;
         else if (sts_clr) sts <= 1'b0;
      end
   end
endmodule

// File: rtl/pci_aper_reporter.sv
module pci_aper_reporter
   import pci_aper_pkg::*;
#(
   parameter int unsigned AD_W   = DFLT_AD_W,
   parameter int unsigned LANE_W = DFLT_LANE_W,
   localparam int unsigned LANES = lane_count(AD_W, LANE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [AD_W-1:0]  ad,
   input  logic [LANES-1:0] cbe_n,
   input  logic             par,
   input  logic             ad_out_en,
   input  logic             serr_en,
   input  logic             perr_resp_en,
   input  logic             sts_clr,
   output logic             serr_n_o,
   output logic             serr_oe,
   output logic             sts_serr
);
   logic             cap_vld;
   logic [AD_W-1:0]  cap_ad;
   logic [LANES-1:0] cap_cbe;
   logic             odd;

   pci_aper_phase #(.AD_W(AD_W), .LANE_W(LANE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
      .ad_out_en(ad_out_en), .cap_vld(cap_vld), .cap_ad(cap_ad), .cap_cbe(cap_cbe)
   );

   pci_aper_parity #(.AD_W(AD_W), .LANE_W(LANE_W)) u_parity (
      .ad_s(cap_ad), .cbe_s(cap_cbe), .par_s(par), .odd(odd)
   );

   pci_aper_report u_report (
      .clk(clk), .rst_n(rst_n), .chk_vld(cap_vld), .chk_odd(odd),
      .serr_en(serr_en), .perr_resp_en(perr_resp_en), .sts_clr(sts_clr),
      .oe(serr_oe), .sts(sts_serr)
   );

   assign serr_n_o = !serr_oe;
endmodule

// File: rtl/pci_aper_checker.sv
module pci_aper_checker (
   input logic clk,
   input logic rst_n,
   input logic frame_n,
   input logic ad_out_en,
   input logic serr_en,
   input logic perr_resp_en,
   input logic sts_clr,
   input logic serr_n_o,
   input logic serr_oe,
   input logic sts_serr
);
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |=> !serr_oe);

   assert_addr_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> ($past(frame_n, 3) == 1'b0) && ($past(frame_n, 4) == 1'b1));

   assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> !$past(ad_out_en, 3));

   assert_serr_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> $past(serr_en));

   assert_perr_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe |-> $past(perr_resp_en));

   assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_serr) |-> $rose(serr_oe));

   assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_serr) |-> $past(sts_clr));

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_quiet_reset_R8: assert (!serr_oe && !sts_serr && serr_n_o);
      end
   end
endmodule

bind pci_aper_reporter pci_aper_checker u_aper_chk (
   .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad_out_en(ad_out_en),
   .serr_en(serr_en), .perr_resp_en(perr_resp_en), .sts_clr(sts_clr),
   .serr_n_o(serr_n_o), .serr_oe(serr_oe), .sts_serr(sts_serr)
);

// File: tb/pci_aper_reporter_bench.sv
module pci_aper_reporter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par = 1'b0;
   logic        ad_out_en = 1'b0;
   logic        serr_en = 1'b0;
   logic        perr_resp_en = 1'b0;
   logic        sts_clr = 1'b0;
   logic        serr_n_o, serr_oe, sts_serr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit mon_on = 1'b0;
   bit done   = 1'b0;
   bit sts_m  = 1'b0;
   string cur_req = "R8";
   int pulse_q[$];
   int clr_q[$];

   always #2.5 clk = ~clk;

   pci_aper_reporter u_pci_aper_reporter (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
      .par(par), .ad_out_en(ad_out_en), .serr_en(serr_en),
      .perr_resp_en(perr_resp_en), .sts_clr(sts_clr),
      .serr_n_o(serr_n_o), .serr_oe(serr_oe), .sts_serr(sts_serr)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
      end
   endtask

   // monitor: pops scoreboard items due in the current cycle
   always @(negedge clk) begin
      if (mon_on) begin
         bit exp_oe;
         bit exp_clr;
         exp_oe  = 1'b0;
         exp_clr = 1'b0;
         if (pulse_q.size() > 0 && pulse_q[0] == cyc) begin
            exp_oe = 1'b1;
            void'(pulse_q.pop_front());
         end
         if (clr_q.size() > 0 && clr_q[0] == cyc) begin
            exp_clr = 1'b1;
            void'(clr_q.pop_front());
         end
         if (exp_oe)       sts_m = 1'b1;
         else if (exp_clr) sts_m = 1'b0;
         check(cur_req, serr_oe, exp_oe, "serr_oe");
         check("R3", serr_n_o, !exp_oe, "serr_n_o");
         check(exp_clr ? "R10" : "R9", sts_serr, sts_m, "sts_serr");
      end
   end

   // driver: one transaction, address phase then ndata data phases
   task automatic txn(input logic [31:0] a, input logic [3:0] c, input bit bad, input bit loc,
                      input bit se, input bit pe, input int ndata, input bit clr_same,
                      input string req);
      int k;
      cur_req = req;
      serr_en = se;
      perr_resp_en = pe;
      @(posedge clk); #1;
      k = cyc;
      frame_n = 1'b0; ad = a; cbe_n = c; ad_out_en = loc;
      if (bad && !loc && se && pe) pulse_q.push_back(k + 3);
      @(posedge clk); #1;
      par = (^a) ^ (^c) ^ bad;
      ad = $urandom; cbe_n = 4'($urandom); ad_out_en = 1'b0;
      frame_n = (ndata > 1) ? 1'b0 : 1'b1;
      for (int i = 1; i < ndata; i++) begin
         @(posedge clk); #1;
         ad = $urandom; par = 1'($urandom);
         frame_n = (i == ndata - 1);
      end
      if (clr_same) begin
         @(posedge clk); #1;
         sts_clr = 1'b1;
         clr_q.push_back(k + 3);
         @(posedge clk); #1;
         sts_clr = 1'b0;
      end
      while (cyc < k + 4) begin
         @(posedge clk); #1;
      end
      frame_n = 1'b1;
   endtask

   task automatic clear_sts();
      cur_req = "R10";
      @(posedge clk); #1;
      sts_clr = 1'b1;
      clr_q.push_back(cyc + 1);
      @(posedge clk); #1;
      sts_clr = 1'b0;
   endtask

   initial begin
      // R8: activity with bad parity during reset must not drive the line
      serr_en = 1'b1; perr_resp_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); #1;
         frame_n = i[0]; ad = $urandom; cbe_n = 4'($urandom); par = 1'($urandom);
         @(negedge clk);
         check("R8", serr_oe, 1'b0, "serr_oe in reset");
         check("R8", sts_serr, 1'b0, "sts_serr in reset");
      end
      frame_n = 1'b1;
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      mon_on = 1'b1;
      @(posedge clk); #1;

      txn(32'h1234_5678, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b0, "R2");
      txn(32'h1234_5678, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, "R3");
      clear_sts();
      txn(32'hFFFF_0000, 4'hB, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b0, "R4");
      txn(32'h0000_0001, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b0, "R5");
      txn(32'h8000_0000, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b0, "R6");
      txn(32'hA5A5_5A5A, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 4, 1'b0, "R7");
      txn(32'h0F0F_F0F0, 4'h2, 1'b1, 1'b0, 1'b1, 1'b1, 3, 1'b0, "R1");
      clear_sts();
      clear_sts();
      for (int i = 0; i < 8; i++)
         txn($urandom, 4'($urandom), 1'(i % 2), 1'b0, 1'b1, 1'b1, 1 + (i % 3), 1'b0, "R2");
      txn(32'hDEAD_BEEF, 4'hC, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, "R10");
      clear_sts();
      txn(32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1, "R10");
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R3", 1'(pulse_q.size() == 0), 1'b1, "scoreboard drained");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule